// File: doc/BRIEF.md
# Bus Read Data Parity Checker

This block watches read data that arrives on a 64-bit processor bus, split into a high word and a low word. Each of the eight byte lanes has its own parity bit, and the block checks odd parity on every lane. It looks only at beats that are acknowledged and that belong to a read. On a normal read all eight lanes are checked, even when the transfer is shorter than eight bytes. On a direct-store read only the four high-word lanes count.

A bad beat that is found while checking is enabled is sent down a two-stage pipeline. The result appears on the second clock after the acknowledge, as a one-cycle pulse. A reporting state machine sends each bad beat one of two ways, using the machine-check enable bit that was sampled with the beat:

- When that bit was set, the block pulses the error output together with a machine-check request.
- When that bit was clear, it pulses a checkstop request.

The reporting state machine has three states:

- `RPT_IDLE`: nothing is reported.
- `RPT_MCHK`: the error output and the machine-check request are high.
- `RPT_CHKSTOP`: the checkstop request is high.

The state machine enters a state in every cycle, chosen from the capture stage:

- No bad beat is captured: the next state is `RPT_IDLE`.
- A bad beat is captured with machine-check enabled: the next state is `RPT_MCHK`.
- A bad beat is captured with machine-check disabled: the next state is `RPT_CHKSTOP`.

Every state lasts one cycle unless the next captured beat selects it again.

Top module: `rdp_read_parity_chk`

## Requirements
- R1: Lane i (0..7) is byte i of the 64-bit value {data_hi, data_lo}, counted from the most significant byte. Lane 0 is data_hi[31:24] and lane 7 is data_lo[7:0]. par[i] is that lane's odd parity bit. A lane is in error when its 8 data bits plus par[i] hold an even number of ones.
- R2: On a normal read (dstore=0), an error on any of the eight lanes makes the beat bad, whatever the transfer size.
- R3: On a direct-store read (dstore=1), only lanes 0..3 (the high word, par[0..3]) are checked. Errors on lanes 4..7 produce no output.
- R4: When chk_en=0 on the acknowledged beat, no output pulses, whatever the parity.
- R5: A beat with rd=0 (write) or ack=0 never produces any output pulse.
- R6: A bad beat sampled with mce=1 pulses parity_err and mchk_req together, and chkstop_req stays low.
- R7: A bad beat sampled with mce=0 pulses chkstop_req, and parity_err and mchk_req stay low.
- R8: Suppose a beat is acknowledged at rising edge k. Its output pulse is driven from edge k+1 to edge k+2, which is the second clock after the acknowledge, and it lasts exactly one cycle.
- R9: Back-to-back acknowledged beats are reported independently, each in its own cycle, and none is lost.
- R10: A synchronous active-high rst clears both pipeline stages. No outputs appear during reset, or in the two cycles after a reset that hit a pending bad beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| data_hi | input | 32 | High data word (lanes 0..3) |
| data_lo | input | 32 | Low data word (lanes 4..7) |
| par | input | 8 | Odd parity bit per lane, par[i] for lane i |
| ack | input | 1 | Data-transfer acknowledge for this beat |
| rd | input | 1 | 1 = read beat, 0 = write beat |
| dstore | input | 1 | Direct-store transaction flag |
| chk_en | input | 1 | Parity checking enable |
| mce | input | 1 | Machine-check enable bit |
| parity_err | output | 1 | Data parity error pulse |
| mchk_req | output | 1 | Machine-check exception request pulse |
| chkstop_req | output | 1 | Checkstop request pulse |

## Verification
The bench builds the block with its default parameters: eight lanes of eight bits. That is the only setting in which the direct-store mask covers exactly the four high-word lanes, and in which every one of the eight lane positions can be hit one at a time. With these values every pairing of lane, read or write, direct-store flag, enable and machine-check bit is reachable by the random stimulus. Back-to-back bad beats with alternating routes exercise the two-stage pipeline, and a reset arriving just after a bad beat is also covered.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    typedef enum logic [1:0] {
        RPT_IDLE    = 2'd0,
        RPT_MCHK    = 2'd1,
        RPT_CHKSTOP = 2'd2
    } rpt_state_t;
endpackage

// File: rtl/rdp_lane_par.sv
module rdp_lane_par #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_data,
    input  logic              lane_par,
    output logic              lane_bad
);
    // Odd parity: the data bits plus the parity bit must hold an odd count of ones.
    assign lane_bad = ~(^{lane_data, lane_par});
endmodule

// File: rtl/rdp_capture.sv
module rdp_capture (
    input  logic clk,
    input  logic rst,
    input  logic beat_bad,
    input  logic beat_mce,
    output logic s1_bad,
    output logic s1_mce
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_bad <= 1'b0;
            s1_mce <= 1'b0;
        end else begin
            s1_bad <= beat_bad;
            s1_mce <= beat_mce;
        end
    end
endmodule

// File: rtl/rdp_report_fsm.sv
module rdp_report_fsm
    import rdp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic s1_bad,
    input  logic s1_mce,
    output logic parity_err,
    output logic mchk_req,
    output logic chkstop_req
);
    rpt_state_t state_q, state_d;

    always_comb begin
        state_d = RPT_IDLE;
        if (s1_bad) begin
            state_d = s1_mce ? RPT_MCHK : RPT_CHKSTOP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RPT_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        parity_err  = 1'b0;
        mchk_req    = 1'b0;
        chkstop_req = 1'b0;
        unique case (state_q)
            RPT_IDLE:    ;
            RPT_MCHK: begin
                parity_err = 1'b1;
                mchk_req   = 1'b1;
            end
            RPT_CHKSTOP: chkstop_req = 1'b1;
            default:     ;
        endcase
    end

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        !(mchk_req && chkstop_req)); // R7
    AST_PULSE_FROM_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (mchk_req || chkstop_req) |-> $past(s1_bad)); // R8
endmodule

// File: rtl/rdp_read_parity_chk.sv
module rdp_read_parity_chk #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [(LANES*LANE_W)/2-1:0]   data_hi,
    input  logic [(LANES*LANE_W)/2-1:0]   data_lo,
    input  logic [LANES-1:0]              par,
    input  logic                          ack,
    input  logic                          rd,
    input  logic                          dstore,
    input  logic                          chk_en,
    input  logic                          mce,
    output logic                          parity_err,
    output logic                          mchk_req,
    output logic                          chkstop_req
);
    localparam int DATA_W   = LANES * LANE_W;
    localparam int HI_LANES = LANES / 2;

    logic [DATA_W-1:0] bus_word;
    logic [LANES-1:0]  lane_bad;
    logic [LANES-1:0]  lane_mask;
    logic              beat_live;
    logic              beat_bad;
    logic              s1_bad;
    logic              s1_mce;

    assign bus_word = {data_hi, data_lo};

    // Lane 0 is the most significant byte of the bus.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rdp_lane_par #(.LANE_W(LANE_W)) u_lane (
            .lane_data (bus_word[DATA_W-1-i*LANE_W -: LANE_W]),
            .lane_par  (par[i]),
            .lane_bad  (lane_bad[i])
        );
        if (i < HI_LANES) begin : g_hi
            assign lane_mask[i] = 1'b1;
        end else begin : g_lo
            assign lane_mask[i] = ~dstore;
        end
    end

    assign beat_live = ack && rd && chk_en;
    assign beat_bad  = beat_live && |(lane_bad & lane_mask);

    rdp_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .beat_bad (beat_bad),
        .beat_mce (mce),
        .s1_bad   (s1_bad),
        .s1_mce   (s1_mce)
    );

    rdp_report_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .s1_bad      (s1_bad),
        .s1_mce      (s1_mce),
        .parity_err  (parity_err),
        .mchk_req    (mchk_req),
        .chkstop_req (chkstop_req)
    );

    AST_NEEDS_READ_ACK: assert property (@(posedge clk) disable iff (rst)
        (parity_err || chkstop_req) |-> $past(ack && rd, 2)); // R5
    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (parity_err || chkstop_req) |-> $past(chk_en, 2)); // R4
    AST_MCHK_ROUTE: assert property (@(posedge clk) disable iff (rst)
        mchk_req |-> (parity_err && $past(mce, 2))); // R6
    AST_CHKSTOP_ROUTE: assert property (@(posedge clk) disable iff (rst)
        chkstop_req |-> (!parity_err && !$past(mce, 2))); // R7
    AST_DSTORE_LOW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (beat_live && dstore && !(|(lane_bad[HI_LANES-1:0]))) |=> !s1_bad); // R3
endmodule

// File: tb/tb_rdp_read_parity_chk.sv
module tb_rdp_read_parity_chk;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] data_hi, data_lo;
    logic [7:0]  par;
    logic        ack, rd, dstore, chk_en, mce;
    logic        parity_err, mchk_req, chkstop_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Expected outputs: e1 is for the beat driven last step, e2 for the one before it.
    logic [2:0] e1, e2;
    string      t1, t2;

    always #10 clk = ~clk;

    rdp_read_parity_chk dut (
        .clk(clk), .rst(rst), .data_hi(data_hi), .data_lo(data_lo), .par(par),
        .ack(ack), .rd(rd), .dstore(dstore), .chk_en(chk_en), .mce(mce),
        .parity_err(parity_err), .mchk_req(mchk_req), .chkstop_req(chkstop_req)
    );

    function automatic logic [7:0] lane_of(logic [63:0] w, int i);
        return w[63-8*i -: 8];
    endfunction

    // Parity bits that make lanes odd, then flip the lanes chosen as bad.
    function automatic logic [7:0] make_par(logic [63:0] w, logic [7:0] badm);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(w[63-8*i-b]);
            p[i] = ((ones % 2) == 0) ^ badm[i];
        end
        return p;
    endfunction

    // Returns {parity_err, mchk_req, chkstop_req}.
    function automatic logic [2:0] model(logic [63:0] w, logic [7:0] p, logic a, logic r,
                                         logic ds, logic en, logic m);
        logic bad = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ln = lane_of(w, i);
            int ones = int'(p[i]);
            for (int b = 0; b < 8; b++) ones += int'(ln[b]);
            if ((ones % 2) == 0 && (i < 4 || !ds)) bad = 1'b1;
        end
        if (!(a && r && en && bad)) return 3'b000;
        return m ? 3'b110 : 3'b001;
    endfunction

    task automatic check_out();
        n_checks++;
        if ({parity_err, mchk_req, chkstop_req} !== e2) begin
            n_fail++;
            $display("FAIL %s: {err,mchk,chkstop} actual=%b expected=%b", t2,
                     {parity_err, mchk_req, chkstop_req}, e2);
        end
    endtask

    task automatic step(logic r_rst, logic [63:0] w, logic [7:0] badm, logic a, logic r,
                        logic ds, logic en, logic m, string tag);
        @(negedge clk);
        check_out();
        rst = r_rst;
        {data_hi, data_lo} = w;
        par    = make_par(w, badm);
        ack    = a;
        rd     = r;
        dstore = ds;
        chk_en = en;
        mce    = m;
        e2 = e1;
        t2 = t1;
        if (r_rst) begin
            e1 = 3'b000;
            e2 = 3'b000;
        end else begin
            e1 = model(w, par, a, r, ds, en, m);
        end
        t1 = tag;
    endtask

    task automatic idle(string tag);
        step(1'b0, 64'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        void'($urandom(32'd4242));
        rst = 1'b1; data_hi = '0; data_lo = '0; par = '0;
        ack = 0; rd = 0; dstore = 0; chk_en = 0; mce = 0;
        e1 = 3'b000; e2 = 3'b000; t1 = "R10"; t2 = "R10";
        // Reset held with a bad read present: nothing may come out.
        repeat (3) step(1'b1, 64'h0123_4567_89AB_CDEF, 8'hFF, 1, 1, 0, 1, 1, "R10");
        idle("R10"); idle("R10"); idle("R10");

        // Clean reads with varied data.
        step(0, 64'hDEAD_BEEF_0000_FFFF, 8'h00, 1, 1, 0, 1, 1, "R1");
        step(0, 64'h8000_0001_7F7F_0102, 8'h00, 1, 1, 0, 1, 0, "R1");
        idle("R1"); idle("R1");
        // Each lane alone in error, normal read, checkstop route.
        for (int i = 0; i < 8; i++) begin
            step(0, {$urandom, $urandom}, 8'h01 << i, 1, 1, 0, 1, 0, "R2");
            idle("R8"); idle("R8");
        end
        // Direct-store: low-word errors ignored, high-word errors reported.
        step(0, 64'h1111_2222_3333_4444, 8'hF0, 1, 1, 1, 1, 1, "R3");
        idle("R3"); idle("R3");
        step(0, 64'h1111_2222_3333_4444, 8'h04, 1, 1, 1, 1, 1, "R3");
        idle("R3"); idle("R3");
        // Checking disabled.
        step(0, 64'hAAAA_5555_AAAA_5555, 8'hFF, 1, 1, 0, 0, 1, "R4");
        idle("R4"); idle("R4");
        // Write beat and unacknowledged read with bad parity.
        step(0, 64'hCAFE_F00D_1234_5678, 8'hFF, 1, 0, 0, 1, 1, "R5");
        step(0, 64'hCAFE_F00D_1234_5678, 8'hFF, 0, 1, 0, 1, 1, "R5");
        idle("R5"); idle("R5");
        // Machine-check route, then checkstop route.
        step(0, 64'h0F0F_0F0F_F0F0_F0F0, 8'h80, 1, 1, 0, 1, 1, "R6");
        idle("R6"); idle("R6");
        step(0, 64'h0F0F_0F0F_F0F0_F0F0, 8'h02, 1, 1, 0, 1, 0, "R7");
        idle("R7"); idle("R7");
        // Back-to-back bad beats with alternating route, then a clean one between.
        step(0, 64'h1, 8'h01, 1, 1, 0, 1, 1, "R9");
        step(0, 64'h2, 8'h10, 1, 1, 0, 1, 0, "R9");
        step(0, 64'h3, 8'h00, 1, 1, 0, 1, 1, "R9");
        step(0, 64'h4, 8'h20, 1, 1, 0, 1, 1, "R9");
        idle("R9"); idle("R9");
        // Reset right after a bad beat drops it.
        step(0, 64'h5, 8'h01, 1, 1, 0, 1, 1, "R10");
        step(1, 64'h0, 8'h00, 0, 0, 0, 0, 0, "R10");
        idle("R10"); idle("R10"); idle("R10");

        // Constrained random traffic.
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] bm;
            w  = {$urandom, $urandom};
            bm = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
            step(0, w, bm, ($urandom % 4) != 0, ($urandom % 4) != 0,
                 ($urandom % 4) == 0, ($urandom % 8) != 0, 1'($urandom), "R8");
        end
        idle("R8"); idle("R8"); idle("R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule